// File: doc/BRIEF.md
# Pipelined local-alignment threshold filter

This block screens a stream of database sequences against one fixed query sequence and flags every database sequence whose best local-alignment score is above a programmable threshold. It uses affine gap costs. The block has one processing cell for every (query residue, database residue) pair. The cells are grouped by anti-diagonal into a linear pipeline of `Q_LEN+DB_LEN-1` stages. Every stage holds a different database sequence, so many sequences are in the array at the same time.

Each stage period lasts two clock cycles. In the first cycle the cells compute their horizontal and vertical gap terms. In the second cycle they compute their local score, and the whole pipeline advances by one stage. A new sequence can enter on every advance. The sequence carries an 8-bit tag, a valid bit and a sticky hit flag. The hit flag collects threshold hits from every stage the sequence passes. It leaves the last stage with the tag, so a host can keep the tags of the selected sequences and discard the rest.

Top module: `sw_select_pipe`

## Requirements
- R1: A sequence accepted on an advance edge appears at `out_valid_o`/`out_tag_o`/`out_sel_o` exactly K = Q_LEN+DB_LEN-1 stage periods (2K clock cycles) later. The outputs change only on advance edges.
- R2: `ready_o` is low in the first cycle after reset and then alternates every cycle. The inputs are sampled only at the clock edge that ends a cycle with `ready_o` high. Input values in other cycles have no effect on any output.
- R3: `out_sel_o` is high exactly when the slot is valid and the largest local score H(i,j) of the sequence is greater than the threshold. The recurrence uses these terms, with every term 0 at i=0 or j=0:
  - E(i,j) = max(E(i,j-1)-GAP_EXT, H(i,j-1)-GAP_OPEN)
  - F(i,j) = max(F(i-1,j)-GAP_EXT, H(i-1,j)-GAP_OPEN)
  - H(i,j) = max(0, E, F, H(i-1,j-1)+w)
  - w is MATCH_SC for equal residues and MISMATCH_SC otherwise.
- R4: The comparison is strict: a sequence whose best score equals `thresh_i` is not selected.
- R5: `out_tag_o` equals the tag that was given with the sequence at entry.
- R6: A slot entered with `in_valid_i` low leaves with `out_valid_o` and `out_sel_o` both low, whatever `in_seq_i` held.
- R7: The hit flag starts cleared for every new sequence. A hit by the preceding sequence never carries into the next one.
- R8: Sequences may enter on consecutive advances, one per stage period. Each sequence gets its own result.
- R9: During and after reset, `out_valid_o`, `out_sel_o` and `ready_o` are low. The first K stage periods after reset produce only invalid slots.
- R10: Residue k (counting from 1) of `in_seq_i` is bits [(k-1)*RES_W +: RES_W], and `query_i` uses the same layout. Residue order affects the score.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| query_i | input | Q_LEN*RES_W | Fixed query residues, held stable while sequences are in flight |
| thresh_i | input | SCORE_W-1 | Selection threshold (unsigned), held stable while sequences are in flight |
| in_valid_i | input | 1 | Slot entering stage 1 holds a sequence |
| in_tag_i | input | TAG_W | Identifier of the entering sequence |
| in_seq_i | input | DB_LEN*RES_W | Residues of the entering database sequence |
| ready_o | output | 1 | High in the cycle whose closing edge advances the pipeline and samples the inputs |
| out_valid_o | output | 1 | Slot leaving the last stage holds a sequence |
| out_tag_o | output | TAG_W | Identifier of the leaving sequence |
| out_sel_o | output | 1 | Leaving sequence scored above the threshold somewhere |

## Verification
A cell with a wrong gap or score register changes the hit flag of only the sequences that cross that cell. The error is visible at `out_sel_o` exactly K stage periods after the affected sequence entered. The bench therefore compares every output on every cycle against an independent full dynamic-programming score, for both directed and random sequences. A fault in the diagonal buffer or in the stage shift moves results onto neighbouring tags, or shifts them by one period. Back-to-back traffic that alternates hit and miss exposes this on the next departing sequence. A phase error shows up within two cycles as a wrong `ready_o` or a change in an output between advances.

// File: rtl/sw_pkg.sv
`timescale 1ns/1ps
package sw_pkg;
  localparam int SCORE_W = 12;
  localparam int TAG_W   = 8;

  typedef logic signed [SCORE_W-1:0] score_t;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic             sel;
  } slot_t;

  function automatic score_t smax(score_t a, score_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sw_phase_gen.sv
`timescale 1ns/1ps
module sw_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic adv_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= ~phase_q;
  end

  assign adv_o = phase_q;

  AST_PHASE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_q |=> phase_q); // R2
  AST_PHASE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q |=> !phase_q); // R2
endmodule

// File: rtl/sw_cell.sv
`timescale 1ns/1ps
module sw_cell import sw_pkg::*; #(
  parameter int RES_W       = 2,
  parameter int MATCH_SC    = 2,
  parameter int MISMATCH_SC = -1,
  parameter int GAP_OPEN    = 2,
  parameter int GAP_EXT     = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic [RES_W-1:0] a_i,
  input  logic [RES_W-1:0] b_i,
  input  score_t           e_left_i,
  input  score_t           h_left_i,
  input  score_t           f_up_i,
  input  score_t           h_up_i,
  input  score_t           h_diag_i,
  output score_t           e_o,
  output score_t           f_o,
  output score_t           h_o,
  output score_t           hbuf_o,
  output score_t           h_next_o
);
  localparam score_t MATCH_V = score_t'(MATCH_SC);
  localparam score_t MISM_V  = score_t'(MISMATCH_SC);
  localparam score_t GO_V    = score_t'(GAP_OPEN);
  localparam score_t GE_V    = score_t'(GAP_EXT);
  localparam score_t NEG_GO  = score_t'(-GAP_OPEN);

  score_t e_q, f_q, h_q, hb_q;
  score_t w_s, diag_s, h_next;

  assign w_s    = (a_i == b_i) ? MATCH_V : MISM_V;
  assign diag_s = h_diag_i + w_s;
  assign h_next = smax(smax('0, e_q), smax(f_q, diag_s));

  // gap terms on the calc phase, score and diagonal buffer on the advance phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q  <= '0;
      f_q  <= '0;
      h_q  <= '0;
      hb_q <= '0;
    end else if (!adv_i) begin
      e_q <= smax(e_left_i - GE_V, h_left_i - GO_V);
      f_q <= smax(f_up_i - GE_V, h_up_i - GO_V);
    end else begin
      h_q  <= h_next;
      hb_q <= h_q;
    end
  end

  assign e_o      = e_q;
  assign f_o      = f_q;
  assign h_o      = h_q;
  assign hbuf_o   = hb_q;
  assign h_next_o = h_next;

  AST_H_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_q >= 0); // R3
  AST_GAP_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (e_q >= NEG_GO) && (f_q >= NEG_GO)); // R3
  AST_H_ON_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(h_q) && $stable(hb_q)); // R1
  AST_GAP_ON_CALC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> $stable(e_q) && $stable(f_q)); // R1
endmodule

// File: rtl/sw_stage_chain.sv
`timescale 1ns/1ps
module sw_stage_chain import sw_pkg::*; #(
  parameter int NSTAGE = 9,
  parameter int SEQ_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              in_valid_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  input  logic [SEQ_W-1:0]  in_seq_i,
  input  logic [NSTAGE-1:0] stage_hit_i,
  output logic [SEQ_W-1:0]  seq_o [NSTAGE],
  output logic              out_valid_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic              out_sel_o
);
  slot_t            stage_q [NSTAGE];
  logic [SEQ_W-1:0] seq_q   [NSTAGE];
  slot_t            out_q;

  function automatic slot_t step(slot_t s, logic hit);
    slot_t r;
    r     = s;
    r.sel = s.valid & (s.sel | hit);
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NSTAGE; k++) begin
        stage_q[k] <= '0;
        seq_q[k]   <= '0;
      end
      out_q <= '0;
    end else if (adv_i) begin
      stage_q[0] <= '{valid: in_valid_i, tag: in_tag_i, sel: 1'b0};
      seq_q[0]   <= in_seq_i;
      for (int k = 1; k < NSTAGE; k++) begin
        stage_q[k] <= step(stage_q[k-1], stage_hit_i[k-1]);
        seq_q[k]   <= seq_q[k-1];
      end
      out_q <= step(stage_q[NSTAGE-1], stage_hit_i[NSTAGE-1]);
    end
  end

  assign seq_o       = seq_q;
  assign out_valid_o = out_q.valid;
  assign out_tag_o   = out_q.tag;
  assign out_sel_o   = out_q.sel;

  AST_EMPTY_NO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !out_sel_o); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && stage_q[NSTAGE-1].valid && stage_q[NSTAGE-1].sel |=> out_sel_o); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(out_valid_o) && $stable(out_tag_o) && $stable(out_sel_o)); // R1
endmodule

// File: rtl/sw_select_pipe.sv
`timescale 1ns/1ps
module sw_select_pipe import sw_pkg::*; #(
  parameter int Q_LEN       = 4,
  parameter int DB_LEN      = 6,
  parameter int RES_W       = 2,
  parameter int MATCH_SC    = 2,
  parameter int MISMATCH_SC = -1,
  parameter int GAP_OPEN    = 2,
  parameter int GAP_EXT     = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [Q_LEN*RES_W-1:0] query_i,
  input  logic [SCORE_W-2:0]     thresh_i,
  input  logic                   in_valid_i,
  input  logic [TAG_W-1:0]       in_tag_i,
  input  logic [DB_LEN*RES_W-1:0] in_seq_i,
  output logic                   ready_o,
  output logic                   out_valid_o,
  output logic [TAG_W-1:0]       out_tag_o,
  output logic                   out_sel_o
);
  localparam int NSTAGE = Q_LEN + DB_LEN - 1;
  localparam int SEQ_W  = DB_LEN * RES_W;

  logic             adv;
  logic [SEQ_W-1:0] stage_seq [NSTAGE];
  logic [NSTAGE-1:0] stage_hit;
  logic [Q_LEN-1:0] term_w [NSTAGE];
  score_t           thr_s;

  score_t e_w    [Q_LEN][DB_LEN];
  score_t f_w    [Q_LEN][DB_LEN];
  score_t h_w    [Q_LEN][DB_LEN];
  score_t hb_w   [Q_LEN][DB_LEN];
  score_t hn_w   [Q_LEN][DB_LEN];
  logic   hit_w  [Q_LEN][DB_LEN];

  assign thr_s = {1'b0, thresh_i};

  sw_phase_gen u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_o  (adv)
  );

  for (genvar r = 0; r < Q_LEN; r++) begin : g_row
    for (genvar c = 0; c < DB_LEN; c++) begin : g_col
      score_t el, hl, fu, hu, hd;

      if (c == 0) begin : g_left_edge
        assign el = '0;
        assign hl = '0;
      end else begin : g_left
        assign el = e_w[r][c-1];
        assign hl = h_w[r][c-1];
      end

      if (r == 0) begin : g_top_edge
        assign fu = '0;
        assign hu = '0;
      end else begin : g_up
        assign fu = f_w[r-1][c];
        assign hu = h_w[r-1][c];
      end

      if (r == 0 || c == 0) begin : g_diag_edge
        assign hd = '0;
      end else begin : g_diag
        assign hd = hb_w[r-1][c-1];
      end

      sw_cell #(
        .RES_W       (RES_W),
        .MATCH_SC    (MATCH_SC),
        .MISMATCH_SC (MISMATCH_SC),
        .GAP_OPEN    (GAP_OPEN),
        .GAP_EXT     (GAP_EXT)
      ) u_cell (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .adv_i    (adv),
        .a_i      (query_i[r*RES_W +: RES_W]),
        .b_i      (stage_seq[r+c][c*RES_W +: RES_W]),
        .e_left_i (el),
        .h_left_i (hl),
        .f_up_i   (fu),
        .h_up_i   (hu),
        .h_diag_i (hd),
        .e_o      (e_w[r][c]),
        .f_o      (f_w[r][c]),
        .h_o      (h_w[r][c]),
        .hbuf_o   (hb_w[r][c]),
        .h_next_o (hn_w[r][c])
      );

      assign hit_w[r][c] = (hn_w[r][c] > thr_s);
    end
  end

  // gather cell hits per anti-diagonal stage
  for (genvar st = 0; st < NSTAGE; st++) begin : g_stage
    for (genvar r = 0; r < Q_LEN; r++) begin : g_term
      localparam int C = st - r;
      if (C >= 0 && C < DB_LEN) begin : g_on
        assign term_w[st][r] = hit_w[r][C];
      end else begin : g_off
        assign term_w[st][r] = 1'b0;
      end
    end
    assign stage_hit[st] = |term_w[st];
  end

  sw_stage_chain #(
    .NSTAGE (NSTAGE),
    .SEQ_W  (SEQ_W)
  ) u_chain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .in_valid_i  (in_valid_i),
    .in_tag_i    (in_tag_i),
    .in_seq_i    (in_seq_i),
    .stage_hit_i (stage_hit),
    .seq_o       (stage_seq),
    .out_valid_o (out_valid_o),
    .out_tag_o   (out_tag_o),
    .out_sel_o   (out_sel_o)
  );

  assign ready_o = adv;

  AST_READY_LOW_IN_RESET: assert property (@(posedge clk_i)
    !rst_ni |-> !ready_o && !out_valid_o); // R9
endmodule

// File: tb/sw_select_pipe_tb.sv
`timescale 1ns/1ps
module sw_select_pipe_tb_top;
  localparam int Q  = 4;
  localparam int N  = 6;
  localparam int RW = 2;
  localparam int MA = 2;
  localparam int MI = -1;
  localparam int GO = 2;
  localparam int GE = 1;
  localparam int K  = Q + N - 1;
  localparam int QW = Q * RW;
  localparam int SW = N * RW;

  typedef struct packed {
    bit       v;
    bit [7:0] t;
    bit       s;
  } ent_t;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [QW-1:0] query;
  logic [10:0]   thr;
  logic          in_valid;
  logic [7:0]    in_tag;
  logic [SW-1:0] in_seq;
  logic          ready_o, out_valid_o, out_sel_o;
  logic [7:0]    out_tag_o;

  int    total = 0;
  int    bad   = 0;
  bit    exp_ready, exp_v, exp_s;
  bit [7:0] exp_t;
  string exp_req;
  ent_t  pq[$];
  string lq[$];

  always #2.5 clk = ~clk;

  sw_select_pipe dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .query_i     (query),
    .thresh_i    (thr),
    .in_valid_i  (in_valid),
    .in_tag_i    (in_tag),
    .in_seq_i    (in_seq),
    .ready_o     (ready_o),
    .out_valid_o (out_valid_o),
    .out_tag_o   (out_tag_o),
    .out_sel_o   (out_sel_o)
  );

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // full local-alignment matrix, independent of the array's wavefront timing
  function automatic int best_score(logic [QW-1:0] qv, logic [SW-1:0] sv);
    int h [0:Q][0:N];
    int e [0:Q][0:N];
    int f [0:Q][0:N];
    int best = 0;
    for (int i = 0; i <= Q; i++)
      for (int j = 0; j <= N; j++) begin
        h[i][j] = 0; e[i][j] = 0; f[i][j] = 0;
      end
    for (int i = 1; i <= Q; i++)
      for (int j = 1; j <= N; j++) begin
        int w;
        w = (qv[(i-1)*RW +: RW] == sv[(j-1)*RW +: RW]) ? MA : MI;
        e[i][j] = imax(e[i][j-1] - GE, h[i][j-1] - GO);
        f[i][j] = imax(f[i-1][j] - GE, h[i-1][j] - GO);
        h[i][j] = imax(imax(0, e[i][j]), imax(f[i][j], h[i-1][j-1] + w));
        best = imax(best, h[i][j]);
      end
    return best;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one cycle: check outputs now, drive inputs for the coming edge, advance the model
  task automatic cyc(bit v, bit [7:0] t, logic [SW-1:0] s, string req);
    ent_t n, o;
    chk("R2", "ready", int'(ready_o), int'(exp_ready));
    chk("R1", "out_valid", int'(out_valid_o), int'(exp_v));
    if (exp_v) chk("R5", "out_tag", int'(out_tag_o), int'(exp_t));
    chk(exp_req, "out_sel", int'(out_sel_o), int'(exp_s));
    if (exp_ready) begin
      in_valid = v;
      in_tag   = t;
      in_seq   = s;
      n.v = v;
      n.t = t;
      n.s = v && (best_score(query, s) > int'(thr));
      pq.push_back(n);
      lq.push_back(req);
      o       = pq.pop_front();
      exp_req = lq.pop_front();
      exp_v   = o.v;
      exp_t   = o.t;
      exp_s   = o.s;
    end else begin
      // R2: junk on non-advance cycles must be ignored
      in_valid = 1'b1;
      in_tag   = 8'hEE;
      in_seq   = SW'($urandom);
    end
    exp_ready = !exp_ready;
    @(negedge clk);
  endtask

  task automatic send(bit v, bit [7:0] t, logic [SW-1:0] s, string req);
    if (!exp_ready) cyc(1'b0, 8'h00, '0, req);
    cyc(v, t, s, req);
  endtask

  task automatic flush();
    for (int i = 0; i < K + 1; i++) send(1'b0, 8'h00, '0, "R6");
  endtask

  // residues listed first-to-last, residue 1 at the low bits (R10)
  function automatic logic [SW-1:0] mk(int r1, int r2, int r3, int r4, int r5, int r6);
    return {RW'(r6), RW'(r5), RW'(r4), RW'(r3), RW'(r2), RW'(r1)};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_ni   = 1'b0;
    in_valid = 1'b0;
    in_tag   = '0;
    in_seq   = '0;
    query    = {2'd3, 2'd2, 2'd1, 2'd0};
    thr      = 11'd7;
    exp_ready = 1'b0;
    exp_v = 1'b0; exp_t = '0; exp_s = 1'b0; exp_req = "R9";
    for (int i = 0; i < K; i++) begin
      pq.push_back('0);
      lq.push_back("R9");
    end
    repeat (3) @(negedge clk);
    chk("R9", "reset out_valid", int'(out_valid_o), 0);
    chk("R9", "reset out_sel", int'(out_sel_o), 0);
    chk("R9", "reset ready", int'(ready_o), 0);
    rst_ni = 1'b1;

    // threshold 7: exact query copy scores 8
    send(1'b1, 8'h11, mk(0,1,2,3,0,0), "R3");
    send(1'b1, 8'h12, mk(0,0,0,0,0,0), "R7");
    send(1'b1, 8'h13, mk(2,2,0,1,2,3), "R8");
    send(1'b1, 8'h14, mk(1,1,1,1,1,1), "R8");
    send(1'b1, 8'h15, mk(0,1,2,3,3,3), "R8");
    send(1'b0, 8'h16, mk(0,1,2,3,0,1), "R6");
    send(1'b1, 8'h17, mk(3,2,1,0,3,2), "R10");
    send(1'b1, 8'h18, mk(0,1,0,2,3,0), "R3");
    flush();

    // threshold equal to the best score: strictly greater required
    thr = 11'd8;
    send(1'b1, 8'h21, mk(0,1,2,3,0,0), "R4");
    send(1'b1, 8'h22, mk(1,0,1,2,3,1), "R4");
    flush();

    thr = 11'd5;
    for (int i = 0; i < 40; i++)
      send(($urandom % 5) != 0, 8'(i + 8'h40), SW'($urandom), "R3");
    flush();

    query = QW'($urandom);
    thr   = 11'd3;
    for (int i = 0; i < 30; i++)
      send(($urandom % 4) != 0, 8'(i + 8'h80), SW'($urandom), "R3");
    flush();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule